// File: doc/BRIEF.md
# Three-Line Handshake Byte Fetcher

This block pulls a single byte from a slow external device over an 8-bit parallel bus. The system side starts a fetch with a one-cycle strobe. The block then raises a request line for a fixed number of clocks and drops it. It waits as long as it takes for the device to raise its ready flag, and lets the bus settle for a clock before it latches the byte. It then raises an acknowledge line for the same fixed number of clocks.

The ready flag comes from another clock domain, so it passes through a two-flop synchronizer before the controller uses it. The transaction does not finish until the device has lowered ready again. At that point the block raises a one-cycle done strobe and the captured byte is held on its output. Because of this rule, one ready assertion can never be captured twice. A start strobe that arrives while a fetch is still running has no effect.

Top module: `hsk_byte_fetch`

## Requirements
- R1: After reset, reqOut, ackOut, busy and doneStb are 0 and capByte is 0x00.
- R2: A startStb seen while idle makes reqOut high from the next cycle for exactly PULSE_CYC cycles (default 3), and busy rises with it. reqOut and ackOut are never high together.
- R3: After the request pulse ends, the block waits with ackOut low and busy high for as long as rdyIn stays low, with no time limit.
- R4: rdyIn passes through two synchronizer flops. The bus is latched on the third rising edge after the first edge that samples rdyIn high. A bus value that changes within the first two cycles after ready rises is therefore the one captured.
- R5: ackOut rises in the same cycle that capByte takes the new byte, and stays high for exactly PULSE_CYC cycles.
- R6: doneStb is high for exactly one cycle per fetch. It comes only after ackOut has cleared, and capByte equals the fetched byte while doneStb is high.
- R7: A startStb while busy is high is ignored. The ongoing fetch produces exactly one request pulse, and no request follows after done.
- R8: After acknowledge, busy stays high and doneStb stays low for as long as rdyIn remains high. Only one byte is captured per ready assertion, and busy falls only after the done strobe.
- R9: capByte changes only at a capture. Bus activity while idle or during acknowledge leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | One-cycle command to fetch a byte |
| busy | output | 1 | High from request until the done strobe |
| doneStb | output | 1 | One-cycle completion strobe |
| capByte | output | 8 | Last captured byte |
| reqOut | output | 1 | Request line to device, active high |
| rdyIn | input | 1 | Device ready flag, asynchronous, active high |
| ackOut | output | 1 | Acknowledge line to device, active high |
| devData | input | 8 | Parallel data bus from device |

## Verification
The device model answers each request after a random delay with a random byte and holds ready for a random time after acknowledge. This separates correct capture from off-by-one pulse widths and from early or late completion. Directed cases add a very long ready delay, to show there is no hidden timeout, and a bus change two cycles after ready rises, which shows the settle sample lands after synchronization. Further directed cases pulse start in the middle of a fetch and toggle the bus while idle. These separate a correct ignore from a restarted or corrupted transaction.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_SAMPLE,
    ST_ACK,
    ST_RELEASE,
    ST_DONE
  } hskState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;   // restart the pulse-width counter
    logic capLoad;  // latch the device bus
  } ctrlStrb_t;

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/hsk_datapath.sv
module hsk_datapath
  import hsk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] devData,
  output logic [DATA_W-1:0] capByte,
  output logic              pulseDone
);
  localparam int CNT_W = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYC - 1);

  logic [CNT_W-1:0] pulseCnt;
  logic [DATA_W-1:0] capReg;

  // saturating width counter shared by request and acknowledge pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    pulseCnt <= '0;
    else if (strb.cntClr)         pulseCnt <= '0;
    else if (pulseCnt != CNT_LAST) pulseCnt <= pulseCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             capReg <= '0;
    else if (strb.capLoad) capReg <= devData;
  end

  assign pulseDone = (pulseCnt == CNT_LAST);
  assign capByte   = capReg;
endmodule

// File: rtl/hsk_ctrl.sv
module hsk_ctrl
  import hsk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStb,
  input  logic      rdySync,
  input  logic      pulseDone,
  output ctrlStrb_t strb,
  output logic      reqOut,
  output logic      ackOut,
  output logic      busy,
  output logic      doneStb
);
  hskState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt     = state;
    strb.cntClr  = 1'b0;
    strb.capLoad = 1'b0;
    unique case (state)
      ST_IDLE: if (startStb) begin
        stateNxt    = ST_REQ;
        strb.cntClr = 1'b1;
      end
      ST_REQ:     if (pulseDone) stateNxt = ST_WAIT;
      ST_WAIT:    if (rdySync)   stateNxt = ST_SAMPLE;
      ST_SAMPLE: begin
        stateNxt     = ST_ACK;
        strb.capLoad = 1'b1;
        strb.cntClr  = 1'b1;
      end
      ST_ACK:     if (pulseDone) stateNxt = ST_RELEASE;
      ST_RELEASE: if (!rdySync)  stateNxt = ST_DONE;
      ST_DONE:    stateNxt = ST_IDLE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  assign reqOut  = (state == ST_REQ);
  assign ackOut  = (state == ST_ACK);
  assign doneStb = (state == ST_DONE);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/hsk_byte_fetch.sv
module hsk_byte_fetch
  import hsk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  output logic              busy,
  output logic              doneStb,
  output logic [DATA_W-1:0] capByte,
  output logic              reqOut,
  input  logic              rdyIn,
  output logic              ackOut,
  input  logic [DATA_W-1:0] devData
);
  ctrlStrb_t strb;
  logic      rdySync;
  logic      pulseDone;

  hsk_sync #(.STAGES(SYNC_STG)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(rdyIn), .syncOut(rdySync)
  );

  hsk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .rdySync(rdySync),
    .pulseDone(pulseDone), .strb(strb), .reqOut(reqOut), .ackOut(ackOut),
    .busy(busy), .doneStb(doneStb)
  );

  hsk_datapath #(.DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .devData(devData),
    .capByte(capByte), .pulseDone(pulseDone)
  );
endmodule

// File: rtl/hsk_checker.sv
module hsk_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              doneStb,
  input logic [DATA_W-1:0] capByte,
  input logic              reqOut,
  input logic              ackOut
);
  a_r2_req_ack_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(reqOut && ackOut));

  a_r7_req_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqOut) |-> !$past(busy));

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (!ackOut && !reqOut && busy));

  a_r9_cap_only_at_ack: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capByte) |-> $rose(ackOut));

  a_r8_busy_ends_at_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(doneStb));
endmodule

bind hsk_byte_fetch hsk_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .doneStb(doneStb),
  .capByte(capByte), .reqOut(reqOut), .ackOut(ackOut)
);

// File: tb/sim_hsk_byte_fetch.sv
`timescale 1ns/1ps
module sim_hsk_byte_fetch;
  localparam int PULSE = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic       busy, doneStb, reqOut, ackOut;
  logic [7:0] capByte;
  logic       rdyIn = 1'b0;
  logic [7:0] devData = 8'h00;

  int checks = 0;
  int fails  = 0;
  int reqRises = 0;
  int reqRun = 0, ackRun = 0;
  bit prevDone = 1'b0, prevReq = 1'b0;

  always #2.5 clk = ~clk;

  hsk_byte_fetch u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .busy(busy),
    .doneStb(doneStb), .capByte(capByte), .reqOut(reqOut),
    .rdyIn(rdyIn), .ackOut(ackOut), .devData(devData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected capture when the bus may change before the settle sample
  function automatic logic [7:0] expCapture(input logic [7:0] first,
      input logic [7:0] second, input bit changedEarly);
    return changedEarly ? second : first;
  endfunction

  // pulse-width and done monitors, sampled at negedge
  always @(negedge clk) if (rstN) begin
    if (reqOut && !prevReq) reqRises++;
    prevReq = reqOut;
    if (reqOut) reqRun++;
    else if (reqRun != 0) begin
      chk(reqRun == PULSE, "R2", "request width", reqRun, PULSE);
      reqRun = 0;
    end
    if (ackOut) ackRun++;
    else if (ackRun != 0) begin
      chk(ackRun == PULSE, "R5", "ack width", ackRun, PULSE);
      ackRun = 0;
    end
    if (doneStb && prevDone) chk(1'b0, "R6", "done longer than one cycle", 2, 1);
    prevDone = doneStb;
  end

  task automatic fetch(input logic [7:0] val, input int rdyDelay, input int holdHi,
                       input bit pokeStart, input bit changeEarly, input logic [7:0] alt);
    int rises0;
    logic [7:0] exp;
    rises0 = reqRises;
    exp = expCapture(val, alt, changeEarly);
    @(negedge clk) startStb = 1'b1;
    @(negedge clk) startStb = 1'b0;
    chk(reqOut && busy, "R2", "request/busy after start", {reqOut, busy}, 3);
    while (reqOut) @(negedge clk);
    for (int i = 0; i < rdyDelay; i++) begin
      if (pokeStart && i == 0) startStb = 1'b1;
      @(negedge clk);
      startStb = 1'b0;
      if (ackOut || !busy) chk(1'b0, "R3", "wait state left early", {ackOut, busy}, 1);
    end
    chk(!ackOut && busy, "R3", "waiting for ready", {ackOut, busy}, 1);
    devData = val;
    rdyIn = 1'b1;
    if (changeEarly) begin
      @(negedge clk);
      @(negedge clk) devData = alt;
    end
    while (!ackOut) @(negedge clk);
    chk(capByte == exp, "R4", "captured byte at ack", capByte, exp);
    chk(capByte == exp, "R5", "capture with ack rise", capByte, exp);
    devData = ~exp;
    while (ackOut) @(negedge clk);
    chk(capByte == exp, "R9", "byte held through ack", capByte, exp);
    for (int i = 0; i < holdHi; i++) begin
      @(negedge clk);
      if (doneStb || !busy) chk(1'b0, "R8", "finished while ready high", {doneStb, busy}, 1);
    end
    chk(capByte == exp && busy, "R8", "single capture while ready high", capByte, exp);
    rdyIn = 1'b0;
    while (!doneStb) @(negedge clk);
    chk(capByte == exp && !ackOut, "R6", "byte at done", capByte, exp);
    @(negedge clk);
    chk(!busy, "R8", "idle after done", busy, 0);
    chk(reqRises - rises0 == 1, "R7", "request pulses per fetch", reqRises - rises0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(!reqOut && !ackOut && !busy && !doneStb && capByte == 8'h00, "R1",
        "reset state", {reqOut, ackOut, busy, doneStb}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && capByte == 8'h00, "R1", "state after release", capByte, 0);

    fetch(8'hA5, 0, 0, 1'b0, 1'b0, 8'h00);
    fetch(8'h3C, 60, 2, 1'b0, 1'b0, 8'h00);       // R3 long wait
    fetch(8'h11, 4, 1, 1'b0, 1'b1, 8'hE7);        // R4 late bus change captured
    fetch(8'h5A, 6, 20, 1'b1, 1'b0, 8'h00);       // R7 start while busy, R8 long ready
    repeat (6) @(negedge clk);
    chk(!reqOut && !busy, "R7", "no request after ignored start", reqOut, 0);

    for (int i = 0; i < 4; i++) begin             // R9 idle bus activity
      @(negedge clk) devData = 8'($urandom);
    end
    repeat (3) @(negedge clk);
    chk(capByte == 8'h5A, "R9", "idle bus ignored", capByte, 8'h5A);

    for (int n = 0; n < 40; n++)
      fetch(8'($urandom), int'($urandom_range(0, 20)), int'($urandom_range(0, 8)),
            1'($urandom_range(0, 1)), 1'b0, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule